// File: doc/BRIEF.md
# Accumulator Processor with Index Register

This block is a compact multi-cycle processor built around one 16-bit accumulator and one 12-bit index register. It runs out of a single synchronous memory that holds both program and data. Each word is split into a 4-bit operation code in the top bits and a 12-bit address field in the low bits. The processor provides memory loads and stores, add and subtract, doubling and halving of the accumulator, unconditional and sign-conditional jumps, and instructions that read or rewrite only the address field of a memory word. That last group lets a program patch its own instructions. The index-register group allows the same loops to run without patching: indexed operand addressing, a combined zero-test-and-step jump, a truncating load, a sign-extending store and an immediate add.

A host side loads programs and reads results through a separate memory port. The host write path only takes effect while the core is held in reset or has halted. After reset is released, execution starts at address 0 and continues until a halt instruction raises the done flag. Each instruction takes three cycles, or four if it reads memory: fetch, decode, execute and an optional memory-result cycle.

Opcode values: 0 system group, 1 load, 2 store, 3 add, 4 subtract, 5 jump, 6 jump-if-non-negative, 7 address-field load, 8 address-field store, 9 indexed load, 10 indexed add, 11 indexed store, 12 index zero-test jump, 13 index load, 14 index store, 15 index add-immediate. In the system group, field bits [1:0] select the operation: 0 halt, 1 shift left, 2 shift right, 3 halt.

Top module: `acc_ix_cpu`

## Requirements
- R1: While reset is low, and on the first cycle after it, PC, AC and IX read zero and done is low. Execution then fetches its first instruction from address 0.
- R2: Opcode 1 sets AC to M[x]. Opcode 2 writes AC to M[x]. Opcode 3 sets AC to AC+M[x] and opcode 4 sets AC to AC-M[x], both modulo 2^16.
- R3: System-group operation 1 shifts AC left by one place. Operation 2 shifts AC right by one place, copying the sign bit into bit 15.
- R4: Opcode 5 loads PC with x. Opcode 6 loads PC with x when AC bit 15 is 0, including AC equal to zero. Otherwise it falls through to the next word.
- R5: Opcode 7 sets AC to the zero-extended bits [11:0] of M[x]. Opcode 8 replaces bits [11:0] of M[x] with AC[11:0] and keeps bits [15:12].
- R6: Opcodes 9, 10 and 11 (load, add and store) address memory at (x + IX) modulo 4096.
- R7: Opcode 12 jumps to x when IX is zero. Otherwise it increments IX by one and continues with the next word.
- R8: Opcode 13 loads IX with bits [11:0] of M[x]. Opcode 14 writes IX, sign-extended to 16 bits, to M[x]. Opcode 15 adds x to IX modulo 4096.
- R9: A halt (system operation 0 or 3) raises done. After that, PC, AC and IX stay frozen, and PC holds the halt address plus one.
- R10: A vector-add loop C[i]=A[i]+B[i] over n elements, entered with IX=-n, writes all n sums, leaves the word after the C array untouched, and halts.
- R11: An instruction whose address field was rewritten by opcode 8 uses the new field when it next executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| host_we | input | 1 | Host memory write enable; has effect only during reset or after halt |
| host_waddr | input | ADDR_W | Host write address |
| host_wdata | input | WORD_W | Host write data |
| host_raddr | input | ADDR_W | Host read address |
| host_rdata | output | WORD_W | Host read data, valid one cycle after the address |
| done | output | 1 | High once a halt has executed |
| pc_o | output | ADDR_W | Program counter |
| ac_o | output | WORD_W | Accumulator |
| ix_o | output | ADDR_W | Index register |

## Verification
The bench builds the block with its defaults: 16-bit words, 12-bit address fields, a 256-word memory and arithmetic right shift. With a 12-bit index, adding an index of -3 to a base of 43 wraps modulo 4096 to address 40. This exercises the modular effective address that the indexed loop depends on. Arithmetic shift makes the halving of a negative accumulator observable as a sign-preserving result. The 256-word depth holds three separate programs, together with their operands and guard words, in low memory.

// File: rtl/acc_ix_pkg.sv
package acc_ix_pkg;

   typedef enum logic [3:0] {
      OP_SYS   = 4'd0,
      OP_LOAD  = 4'd1,
      OP_STORE = 4'd2,
      OP_ADD   = 4'd3,
      OP_SUB   = 4'd4,
      OP_JUMP  = 4'd5,
      OP_JGE   = 4'd6,
      OP_LDADR = 4'd7,
      OP_STADR = 4'd8,
      OP_LDX   = 4'd9,
      OP_ADDX  = 4'd10,
      OP_STX   = 4'd11,
      OP_JZI   = 4'd12,
      OP_LDI   = 4'd13,
      OP_STI   = 4'd14,
      OP_INCI  = 4'd15
   } opcode_e;

   typedef enum logic [1:0] {
      SYS_HALT = 2'd0,
      SYS_SHL  = 2'd1,
      SYS_SHR  = 2'd2,
      SYS_RSVD = 2'd3
   } sys_e;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_EXEC   = 3'd2,
      ST_MEM    = 3'd3,
      ST_HALT   = 3'd4
   } state_e;

   function automatic logic uses_index(opcode_e op);
      return (op == OP_LDX) || (op == OP_ADDX) || (op == OP_STX);
   endfunction

endpackage

// File: rtl/acc_ix_ram.sv
module acc_ix_ram #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 12,
   parameter int DEPTH  = 256
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              a_we,
   input  logic [WORD_W-1:0] a_wdata,
   output logic [WORD_W-1:0] a_rdata,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_waddr,
   input  logic [WORD_W-1:0] b_wdata,
   input  logic [ADDR_W-1:0] b_raddr,
   output logic [WORD_W-1:0] b_rdata
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int SPAN  = 2 ** ADDR_W;

   if (DEPTH > SPAN || (2 ** IDX_W) != DEPTH) begin : g_bad_depth
      $error("acc_ix_ram: DEPTH must be a power of two no larger than 2**ADDR_W");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic              a_ok, bw_ok, br_ok;
   logic [IDX_W-1:0]  a_idx, bw_idx, br_idx;

   if (DEPTH == SPAN) begin : g_full
      assign a_ok   = 1'b1;
      assign bw_ok  = 1'b1;
      assign br_ok  = 1'b1;
      assign a_idx  = a_addr;
      assign bw_idx = b_waddr;
      assign br_idx = b_raddr;
   end else begin : g_part
      assign a_ok   = (a_addr  < ADDR_W'(DEPTH));
      assign bw_ok  = (b_waddr < ADDR_W'(DEPTH));
      assign br_ok  = (b_raddr < ADDR_W'(DEPTH));
      assign a_idx  = a_addr[IDX_W-1:0];
      assign bw_idx = b_waddr[IDX_W-1:0];
      assign br_idx = b_raddr[IDX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (a_we && a_ok) begin
         mem[a_idx] <= a_wdata;
      end else if (b_we && bw_ok) begin
         mem[bw_idx] <= b_wdata;
      end
      a_rdata <= a_ok  ? mem[a_idx]  : '0;
      b_rdata <= br_ok ? mem[br_idx] : '0;
   end

endmodule

// File: rtl/acc_ix_alu.sv
module acc_ix_alu
   import acc_ix_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int ADDR_W    = 12,
   parameter bit SHR_ARITH = 1'b1
) (
   input  opcode_e           op,
   input  logic [1:0]        sub,
   input  logic [WORD_W-1:0] acc,
   input  logic [WORD_W-1:0] opnd,
   output logic [WORD_W-1:0] res
);

   logic [WORD_W-1:0] shr_val;

   if (SHR_ARITH) begin : g_arith
      assign shr_val = {acc[WORD_W-1], acc[WORD_W-1:1]};
   end else begin : g_logic
      assign shr_val = {1'b0, acc[WORD_W-1:1]};
   end

   always_comb begin
      res = acc;
      case (op)
         OP_LOAD, OP_LDX: res = opnd;
         OP_ADD, OP_ADDX: res = acc + opnd;
         OP_SUB:          res = acc - opnd;
         OP_LDADR:        res = {{(WORD_W-ADDR_W){1'b0}}, opnd[ADDR_W-1:0]};
         OP_SYS: begin
            if (sub == SYS_SHL)      res = {acc[WORD_W-2:0], 1'b0};
            else if (sub == SYS_SHR) res = shr_val;
         end
         default:         res = acc;
      endcase
   end

endmodule

// File: rtl/acc_ix_index.sv
module acc_ix_index
   import acc_ix_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 12
) (
   input  opcode_e           op,
   input  logic [ADDR_W-1:0] ix,
   input  logic [ADDR_W-1:0] fld,
   input  logic [ADDR_W-1:0] mem_lo,
   output logic [ADDR_W-1:0] ea,
   output logic [ADDR_W-1:0] ix_next,
   output logic              ix_zero,
   output logic [WORD_W-1:0] ix_word
);

   localparam int EXT_W = WORD_W - ADDR_W;

   assign ea      = uses_index(op) ? (fld + ix) : fld;
   assign ix_zero = (ix == '0);
   assign ix_word = {{EXT_W{ix[ADDR_W-1]}}, ix};

   always_comb begin
      case (op)
         OP_LDI:  ix_next = mem_lo;
         OP_INCI: ix_next = ix + fld;
         OP_JZI:  ix_next = ix + ADDR_W'(1);
         default: ix_next = ix;
      endcase
   end

endmodule

// File: rtl/acc_ix_cpu.sv
module acc_ix_cpu
   import acc_ix_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int ADDR_W    = 12,
   parameter int MEM_DEPTH = 256,
   parameter bit SHR_ARITH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_waddr,
   input  logic [WORD_W-1:0] host_wdata,
   input  logic [ADDR_W-1:0] host_raddr,
   output logic [WORD_W-1:0] host_rdata,
   output logic              done,
   output logic [ADDR_W-1:0] pc_o,
   output logic [WORD_W-1:0] ac_o,
   output logic [ADDR_W-1:0] ix_o
);

   localparam int OP_W = WORD_W - ADDR_W;
   localparam int MSB  = WORD_W - 1;

   if (OP_W != 4) begin : g_bad_split
      $error("acc_ix_cpu: WORD_W - ADDR_W must leave a 4-bit opcode");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("acc_ix_cpu: ADDR_W must be at least 2");
   end

   state_e            state;
   logic [ADDR_W-1:0] pc, ix;
   logic [WORD_W-1:0] ac, ir;

   opcode_e           op;
   logic [ADDR_W-1:0] fld;
   logic [1:0]        sys;
   assign op  = opcode_e'(ir[MSB -: OP_W]);
   assign fld = ir[ADDR_W-1:0];
   assign sys = fld[1:0];

   logic [ADDR_W-1:0] c_addr;
   logic              c_we;
   logic [WORD_W-1:0] c_wdata, c_rdata;
   logic              host_wr_ok;
   logic [ADDR_W-1:0] ea, ix_next;
   logic              ix_zero;
   logic [WORD_W-1:0] ix_word, alu_res;

   assign host_wr_ok = host_we && (!rst_n || state == ST_HALT);

   acc_ix_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DEPTH(MEM_DEPTH)) u_ram (
      .clk     (clk),
      .a_addr  (c_addr),
      .a_we    (c_we),
      .a_wdata (c_wdata),
      .a_rdata (c_rdata),
      .b_we    (host_wr_ok),
      .b_waddr (host_waddr),
      .b_wdata (host_wdata),
      .b_raddr (host_raddr),
      .b_rdata (host_rdata)
   );

   acc_ix_alu #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SHR_ARITH(SHR_ARITH)) u_alu (
      .op   (op),
      .sub  (sys),
      .acc  (ac),
      .opnd (c_rdata),
      .res  (alu_res)
   );

   acc_ix_index #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_index (
      .op      (op),
      .ix      (ix),
      .fld     (fld),
      .mem_lo  (c_rdata[ADDR_W-1:0]),
      .ea      (ea),
      .ix_next (ix_next),
      .ix_zero (ix_zero),
      .ix_word (ix_word)
   );

   // memory port of the core: fetch address, operand address and store data
   always_comb begin
      c_addr  = (state == ST_FETCH) ? pc : ea;
      c_we    = 1'b0;
      c_wdata = ac;
      if (state == ST_EXEC) begin
         case (op)
            OP_STORE, OP_STX: c_we = 1'b1;
            OP_STI: begin
               c_we    = 1'b1;
               c_wdata = ix_word;
            end
            default: c_we = 1'b0;
         endcase
      end
      if (state == ST_MEM && op == OP_STADR) begin
         c_we    = 1'b1;
         c_wdata = {c_rdata[MSB:ADDR_W], ac[ADDR_W-1:0]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_FETCH;
         pc    <= '0;
         ac    <= '0;
         ix    <= '0;
         ir    <= '0;
      end else begin
         case (state)
            ST_FETCH: state <= ST_DECODE;
            ST_DECODE: begin
               ir    <= c_rdata;
               pc    <= pc + ADDR_W'(1);
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               state <= ST_FETCH;
               case (op)
                  OP_SYS: begin
                     if (sys == SYS_SHL || sys == SYS_SHR) ac <= alu_res;
                     else state <= ST_HALT;
                  end
                  OP_LOAD, OP_ADD, OP_SUB, OP_LDADR, OP_STADR,
                  OP_LDX, OP_ADDX, OP_LDI: state <= ST_MEM;
                  OP_JUMP: pc <= fld;
                  OP_JGE:  if (!ac[MSB]) pc <= fld;
                  OP_JZI: begin
                     if (ix_zero) pc <= fld;
                     else ix <= ix_next;
                  end
                  OP_INCI: ix <= ix_next;
                  default: state <= ST_FETCH;
               endcase
            end
            ST_MEM: begin
               state <= ST_FETCH;
               if (op == OP_LDI) ix <= ix_next;
               else if (op != OP_STADR) ac <= alu_res;
            end
            ST_HALT: state <= ST_HALT;
            default: state <= ST_FETCH;
         endcase
      end
   end

   assign done = (state == ST_HALT);
   assign pc_o = pc;
   assign ac_o = ac;
   assign ix_o = ix;

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pc == '0 && ac == '0 && ix == '0 && state == ST_FETCH));

   assert_jge_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && op == OP_JGE && ac[MSB]) |=> (pc == $past(pc)));

   assert_stadr_same_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MEM && op == OP_STADR) |-> (c_we && c_addr == $past(c_addr)));

   assert_jzi_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && op == OP_JZI && ix != '0) |=>
      (ix == $past(ix) + ADDR_W'(1) && pc == $past(pc)));

   assert_inci_add_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && op == OP_INCI) |=> (ix == $past(ix) + $past(fld)));

   assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALT) |=>
      (state == ST_HALT && $stable(pc) && $stable(ac) && $stable(ix) && !c_we));

endmodule

// File: tb/acc_ix_cpu_test.sv
module acc_ix_cpu_test;

   localparam logic [3:0] K_SYS = 4'd0, K_LOAD = 4'd1, K_STORE = 4'd2, K_ADD = 4'd3,
                          K_SUB = 4'd4, K_JUMP = 4'd5, K_JGE = 4'd6, K_LDADR = 4'd7,
                          K_STADR = 4'd8, K_LDX = 4'd9, K_ADDX = 4'd10, K_STX = 4'd11,
                          K_JZI = 4'd12, K_LDI = 4'd13, K_STI = 4'd14, K_INCI = 4'd15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [11:0] host_waddr = '0;
   logic [15:0] host_wdata = '0;
   logic [11:0] host_raddr = '0;
   logic [15:0] host_rdata;
   logic        done;
   logic [11:0] pc_o, ix_o;
   logic [15:0] ac_o;

   int n_checks = 0;
   int n_fail   = 0;

   typedef struct {
      int          kind;   // 0 memory word, 1 AC, 2 IX, 3 PC, 4 done
      logic [11:0] addr;
      logic [15:0] exp;
      string       req;
   } item_t;

   item_t exp_q[$];
   int    pending  = 0;
   logic  mon_busy = 1'b0;

   always #10 clk = ~clk;

   acc_ix_cpu uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_waddr (host_waddr),
      .host_wdata (host_wdata),
      .host_raddr (host_raddr),
      .host_rdata (host_rdata),
      .done       (done),
      .pc_o       (pc_o),
      .ac_o       (ac_o),
      .ix_o       (ix_o)
   );

   function automatic logic [15:0] enc(logic [3:0] op, logic [11:0] f);
      return {op, f};
   endfunction

   task automatic check(logic ok, string req, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic expect_item(int kind, logic [11:0] addr, logic [15:0] exp, string req);
      item_t it;
      it.kind = kind;
      it.addr = addr;
      it.exp  = exp;
      it.req  = req;
      exp_q.push_back(it);
      pending++;
   endtask

   // monitor: pops expectations once the program has halted and compares
   initial begin
      forever begin
         item_t       it;
         logic [15:0] act;
         wait (pending != 0 && done);
         mon_busy = 1'b1;
         it = exp_q.pop_front();
         pending--;
         @(negedge clk);
         case (it.kind)
            0: begin
               host_raddr = it.addr;
               @(posedge clk);
               @(negedge clk);
               act = host_rdata;
            end
            1: act = ac_o;
            2: act = {4'h0, ix_o};
            3: act = {4'h0, pc_o};
            default: act = {15'h0, done};
         endcase
         check(act == it.exp, it.req, act, it.exp);
         mon_busy = 1'b0;
      end
   end

   task automatic poke(logic [11:0] a, logic [15:0] d);
      @(negedge clk);
      host_we    = 1'b1;
      host_waddr = a;
      host_wdata = d;
      @(posedge clk);
      #1 host_we = 1'b0;
   endtask

   task automatic begin_program();
      wait (pending == 0 && !mon_busy);
      @(negedge clk);
      rst_n = 1'b0;
      for (int a = 0; a < 128; a++) poke(12'(a), 16'h0000);
   endtask

   task automatic start_and_wait();
      @(negedge clk);
      // R1: reset state visible while reset is held
      check(pc_o == 12'h0, "R1 pc", {4'h0, pc_o}, 16'h0);
      check(ac_o == 16'h0, "R1 ac", ac_o, 16'h0);
      check(ix_o == 12'h0, "R1 ix", {4'h0, ix_o}, 16'h0);
      check(done == 1'b0, "R1 done", {15'h0, done}, 16'h0);
      rst_n = 1'b1;
      for (int i = 0; i < 3000 && !done; i++) @(posedge clk);
      @(negedge clk);
      check(done == 1'b1, "R9 halt reached", {15'h0, done}, 16'h1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected halted");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      // ---------- program A: arithmetic, shifts, jumps ----------
      begin_program();
      poke(12'd20, 16'd5);
      poke(12'd21, 16'd7);
      poke(12'd22, 16'd20);
      poke(12'd34, 16'h1111);
      poke(12'd0,  enc(K_LOAD, 12'd20));
      poke(12'd1,  enc(K_ADD, 12'd21));
      poke(12'd2,  enc(K_SUB, 12'd22));
      poke(12'd3,  enc(K_STORE, 12'd30));
      poke(12'd4,  enc(K_SYS, 12'd1));
      poke(12'd5,  enc(K_STORE, 12'd31));
      poke(12'd6,  enc(K_SYS, 12'd2));
      poke(12'd7,  enc(K_SYS, 12'd2));
      poke(12'd8,  enc(K_STORE, 12'd32));
      poke(12'd9,  enc(K_JGE, 12'd12));
      poke(12'd10, enc(K_LOAD, 12'd21));
      poke(12'd11, enc(K_JGE, 12'd14));
      poke(12'd12, enc(K_LOAD, 12'd20));
      poke(12'd13, enc(K_SYS, 12'd0));
      poke(12'd14, enc(K_STORE, 12'd33));
      poke(12'd15, enc(K_JUMP, 12'd17));
      poke(12'd16, enc(K_STORE, 12'd34));
      poke(12'd17, enc(K_SYS, 12'd0));
      start_and_wait();
      expect_item(0, 12'd30, 16'hFFF8, "R2 load/add/sub/store");
      expect_item(0, 12'd31, 16'hFFF0, "R3 shift left");
      expect_item(0, 12'd32, 16'hFFFC, "R3 arithmetic shift right");
      expect_item(0, 12'd33, 16'h0007, "R4 jge taken on positive");
      expect_item(0, 12'd34, 16'h1111, "R4 jump skips store");
      expect_item(1, 12'd0,  16'h0007, "R4 jge fall-through on negative");
      expect_item(3, 12'd0,  16'd18,   "R9 pc after halt");
      expect_item(4, 12'd0,  16'h0001, "R9 done held");

      // ---------- program B: address-field access, self-modification ----------
      begin_program();
      poke(12'd20, 16'h3ABC);
      poke(12'd21, 16'h0123);
      poke(12'd22, 16'h7FFF);
      poke(12'd23, 16'h0055);
      poke(12'd24, 16'h0001);
      poke(12'd31, 16'h2222);
      poke(12'd0,  enc(K_LDADR, 12'd20));
      poke(12'd1,  enc(K_STORE, 12'd30));
      poke(12'd2,  enc(K_LOAD, 12'd21));
      poke(12'd3,  enc(K_STADR, 12'd22));
      poke(12'd4,  enc(K_SUB, 12'd21));
      poke(12'd5,  enc(K_JGE, 12'd7));
      poke(12'd6,  enc(K_STORE, 12'd31));
      poke(12'd7,  enc(K_LDADR, 12'd10));
      poke(12'd8,  enc(K_ADD, 12'd24));
      poke(12'd9,  enc(K_STADR, 12'd10));
      poke(12'd10, enc(K_LOAD, 12'd23));
      poke(12'd11, enc(K_STORE, 12'd32));
      poke(12'd12, enc(K_SYS, 12'd3));
      start_and_wait();
      expect_item(0, 12'd30, 16'h0ABC, "R5 address-field load zero-extends");
      expect_item(0, 12'd22, 16'h7123, "R5 address-field store keeps opcode bits");
      expect_item(0, 12'd31, 16'h2222, "R4 jge taken on zero");
      expect_item(0, 12'd10, 16'h1018, "R11 patched instruction word");
      expect_item(0, 12'd32, 16'h0001, "R11 patched field executed");
      expect_item(1, 12'd0,  16'h0001, "R11 final ac");
      expect_item(3, 12'd0,  16'd13,   "R9 pc after reserved halt");

      // ---------- program C: indexed vector add and index group ----------
      begin_program();
      poke(12'd40, 16'h0003);  poke(12'd50, 16'h0004);
      poke(12'd41, 16'h0100);  poke(12'd51, 16'h0200);
      poke(12'd42, 16'hFFFF);  poke(12'd52, 16'h0002);
      poke(12'd43, 16'h1234);  poke(12'd53, 16'h1111);
      poke(12'd64, 16'hBEEF);
      poke(12'd70, 16'hFFFC);
      poke(12'd71, 16'h5555);
      poke(12'd74, 16'hA123);
      poke(12'd0,  enc(K_LDI, 12'd70));
      poke(12'd1,  enc(K_JZI, 12'd6));
      poke(12'd2,  enc(K_LDX, 12'd43));
      poke(12'd3,  enc(K_ADDX, 12'd53));
      poke(12'd4,  enc(K_STX, 12'd63));
      poke(12'd5,  enc(K_JUMP, 12'd1));
      poke(12'd6,  enc(K_STI, 12'd71));
      poke(12'd7,  enc(K_INCI, 12'hFFE));
      poke(12'd8,  enc(K_STI, 12'd72));
      poke(12'd9,  enc(K_INCI, 12'd5));
      poke(12'd10, enc(K_STI, 12'd73));
      poke(12'd11, enc(K_LDI, 12'd74));
      poke(12'd12, enc(K_SYS, 12'd0));
      start_and_wait();
      expect_item(0, 12'd60, 16'h0007, "R10 element 0");
      expect_item(0, 12'd61, 16'h0300, "R10 element 1");
      expect_item(0, 12'd62, 16'h0001, "R6 wrapped sum element 2");
      expect_item(0, 12'd63, 16'h2345, "R10 element 3");
      expect_item(0, 12'd64, 16'hBEEF, "R10 word past array untouched");
      expect_item(0, 12'd71, 16'h0000, "R7 loop exits with ix zero");
      expect_item(0, 12'd72, 16'hFFFE, "R8 index store sign-extends");
      expect_item(0, 12'd73, 16'h0003, "R8 index add-immediate wraps");
      expect_item(2, 12'd0,  16'h0123, "R8 index load truncates");
      expect_item(1, 12'd0,  16'h2345, "R6 last indexed sum in ac");
      expect_item(3, 12'd0,  16'd13,   "R9 pc after halt");

      wait (pending == 0 && !mon_busy);
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule